// File: doc/BRIEF.md
# Dual-Standard Raster Timing Generator

This block produces the raster timing for a graphics screen whose visible picture is a fixed 288-dot by 192-line window, framed by a border, inside a full television frame. A single input chooses between the 525-line-family timing and the 625-line-family timing, and a second input chooses interlaced or progressive scanning. It is clocked by the master dot clock of the chosen standard. Each clock advances the raster by one dot.

The block drives active-low horizontal, vertical and composite sync and an active-low composite blanking signal. For the display logic it also provides a window-enable flag with the dot and line offsets inside the window, and a border flag. A subcarrier-rate square wave at one quarter of the master clock is produced alongside. Three test-pattern requests select the colour source that downstream RGB logic should use. Pixel fetch and digital-to-analogue conversion sit outside this block.

The standard and scan selections are sampled while reset is held and again at each field boundary, so the raster never changes its geometry in the middle of a field.

Top module: `vid_raster_gen`

## Requirements
- R1: A line lasts 455 clocks when `std_ntsc` is high and 567 clocks when it is low. `hsync_n` is low for the first 68 (525-line) or 94 (625-line) dots of every line and high for the rest of the line.
- R2: After the sync segment, each line has a left border of 44 / 84 dots, the 288-dot window, a right border of 45 / 88 dots and a front porch of 10 / 13 dots. `blank_n` is low during the sync segment and the front porch.
- R3: With `ilace_en` low, a field is 262 (525-line) or 312 (625-line) lines long. Counting lines from 0, `vsync_n` is low on lines 0 to 2. `blank_n` is low on lines 0 to 19 (525-line) or 0 to 24 (625-line). These are followed by a top border of 25 / 47 lines, the 192 window lines and a bottom border of 25 / 48 lines.
- R4: With `ilace_en` high, fields alternate between short (262 / 312 lines) and long (263 / 313 lines), and the first field after reset is short. In a long field, `vsync_n` falls at dot L/2 of line 0 (L is the line length, division rounding down) and rises at dot L/2 of line 3. The extra line is bottom border.
- R5: `csync_n` is low exactly when `hsync_n` or `vsync_n` is low. `blank_n` is low whenever either sync is low.
- R6: `disp_en` is high exactly inside the 288 x 192 window. Inside the window, `pix_x` and `line_y` give the dot and line offset from the top-left corner of the window. Outside the window both are 0.
- R7: `border` is high exactly when `blank_n` is high and `disp_en` is low.
- R8: `fsc` runs at one quarter of the clock rate. It is low for the first two clocks after reset, then high for two clocks, and so on.
- R9: `rgb_sel` encodes the colour source: 0 = picture, 1 = mute colour, 2 = colour bar, 3 = cross-hatch. `tp_mute` has the highest priority, then `tp_bar`, then `tp_hatch`. The output follows the inputs without a clock.
- R10: `std_ntsc` and `ilace_en` are sampled during reset and on the last clock of each field. A change in the middle of a field takes effect from the first dot of the next field.
- R11: In the first clock after reset is released, the raster is at line 0 dot 0. At that point `hsync_n`, `vsync_n`, `csync_n`, `blank_n`, `disp_en` and `fsc` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master dot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| std_ntsc | input | 1 | 1 = 525-line timing, 0 = 625-line timing |
| ilace_en | input | 1 | 1 = interlaced fields |
| tp_mute | input | 1 | Request mute colour over the whole screen |
| tp_bar | input | 1 | Request colour-bar pattern |
| tp_hatch | input | 1 | Request cross-hatch pattern |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| blank_n | output | 1 | Composite blanking, active low |
| disp_en | output | 1 | Inside the display window |
| border | output | 1 | Visible but outside the window |
| pix_x | output | 9 | Dot offset inside the window |
| line_y | output | 8 | Line offset inside the window |
| fsc | output | 1 | Clock divided by four |
| rgb_sel | output | 2 | Colour source code |

## Verification
The properties assume that reset is synchronous and is held across at least one rising edge. They also assume the segment lengths are nonzero, so that sync always ends before the front porch. The standard and scan inputs may change at any time, because the line-length property judges each line by the standard that was in force while that line ran. The stimulus drives every input on the falling edge. It changes the mode either under reset or once in mid-field, to exercise the deferred switch. It holds the test-pattern requests low while the raster is being compared.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
  localparam int TW = 16;
  typedef logic [TW-1:0] tval_t;

  typedef struct packed {
    tval_t hsync;
    tval_t hlead;
    tval_t hact;
    tval_t htrail;
    tval_t hporch;
    tval_t vsync;
    tval_t vblank;
    tval_t vlead;
    tval_t vact;
    tval_t vtrail;
  } tmg_t;

  typedef enum logic [1:0] {
    SRC_PIXEL = 2'd0,
    SRC_MUTE  = 2'd1,
    SRC_BAR   = 2'd2,
    SRC_HATCH = 2'd3
  } src_t;

  function automatic tval_t line_total(tmg_t t);
    return t.hsync + t.hlead + t.hact + t.htrail + t.hporch;
  endfunction

  function automatic tval_t field_total(tmg_t t);
    return t.vsync + t.vblank + t.vlead + t.vact + t.vtrail;
  endfunction

  function automatic tval_t win_x0(tmg_t t);
    return t.hsync + t.hlead;
  endfunction

  function automatic tval_t porch_x0(tmg_t t);
    return line_total(t) - t.hporch;
  endfunction

  function automatic tval_t vis_y0(tmg_t t);
    return t.vsync + t.vblank;
  endfunction

  function automatic tval_t win_y0(tmg_t t);
    return t.vsync + t.vblank + t.vlead;
  endfunction
endpackage

// File: rtl/vrg_line_ctr.sv
module vrg_line_ctr #(
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] line_len,
  output logic [HW-1:0] dot,
  output logic          line_end
);
  assign line_end = (dot >= line_len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)        dot <= '0;
    else if (line_end) dot <= '0;
    else               dot <= dot + 1'b1;
  end
endmodule

// File: rtl/vrg_field_ctr.sv
module vrg_field_ctr #(
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic          std_req,
  input  logic          il_req,
  input  logic [VW-1:0] field_len,
  output logic [VW-1:0] line,
  output logic          odd_field,
  output logic          cur_std,
  output logic          cur_il,
  output logic          field_end
);
  logic [VW-1:0] eff_len;
  logic          last_line;

  assign eff_len   = field_len + VW'(cur_il & odd_field);
  assign last_line = (line >= eff_len - 1'b1);
  assign field_end = line_end & last_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line      <= '0;
      odd_field <= 1'b0;
      cur_std   <= std_req;
      cur_il    <= il_req;
    end else if (line_end) begin
      if (last_line) begin
        line      <= '0;
        odd_field <= il_req & ~odd_field;
        cur_std   <= std_req;
        cur_il    <= il_req;
      end else begin
        line <= line + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vrg_raster_dec.sv
module vrg_raster_dec
  import vrg_pkg::*;
#(
  parameter int HW  = 10,
  parameter int VW  = 9,
  parameter int PXW = 9,
  parameter int PYW = 8
) (
  input  tmg_t           tm,
  input  logic [HW-1:0]  dot,
  input  logic [VW-1:0]  line,
  input  logic           odd_field,
  input  logic           cur_il,
  output logic           hsync_n,
  output logic           vsync_n,
  output logic           blank_n,
  output logic           disp_en,
  output logic           border,
  output logic [PXW-1:0] pix_x,
  output logic [PYW-1:0] line_y
);
  tval_t x, y, half, wx0, wy0;
  logic  h_sync, h_blank, v_sync, v_blank, in_x, in_y;

  always_comb begin
    x    = TW'(dot);
    y    = TW'(line);
    half = line_total(tm) >> 1;
    wx0  = win_x0(tm);
    wy0  = win_y0(tm);

    h_sync  = (x < tm.hsync);
    h_blank = h_sync || (x >= porch_x0(tm));

    if (cur_il && odd_field)
      v_sync = ((y == '0) && (x >= half)) ||
               ((y != '0) && (y < tm.vsync)) ||
               ((y == tm.vsync) && (x < half));
    else
      v_sync = (y < tm.vsync);
    v_blank = (y < vis_y0(tm));

    in_x = (x >= wx0) && (x < wx0 + tm.hact);
    in_y = (y >= wy0) && (y < wy0 + tm.vact);

    hsync_n = ~h_sync;
    vsync_n = ~v_sync;
    blank_n = ~(h_blank | v_blank);
    disp_en = in_x & in_y;
    border  = blank_n & ~disp_en;
    pix_x   = disp_en ? PXW'(x - wx0) : '0;
    line_y  = disp_en ? PYW'(y - wy0) : '0;
  end
endmodule

// File: rtl/vrg_subcarrier.sv
module vrg_subcarrier #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic fsc
);
  localparam int CW = $clog2(DIV);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (cnt == CW'(DIV - 1)) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign fsc = (cnt >= CW'(DIV / 2));
endmodule

// File: rtl/vid_raster_gen.sv
module vid_raster_gen
  import vrg_pkg::*;
#(
  parameter int N_HSYNC  = 68,
  parameter int N_HLEAD  = 44,
  parameter int N_HTRAIL = 45,
  parameter int N_HPORCH = 10,
  parameter int P_HSYNC  = 94,
  parameter int P_HLEAD  = 84,
  parameter int P_HTRAIL = 88,
  parameter int P_HPORCH = 13,
  parameter int ACT_W    = 288,
  parameter int ACT_H    = 192,
  parameter int N_VSYNC  = 3,
  parameter int N_VBLANK = 17,
  parameter int N_VLEAD  = 25,
  parameter int N_VTRAIL = 25,
  parameter int P_VSYNC  = 3,
  parameter int P_VBLANK = 22,
  parameter int P_VLEAD  = 47,
  parameter int P_VTRAIL = 48,
  parameter int FSC_DIV  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      std_ntsc,
  input  logic                      ilace_en,
  input  logic                      tp_mute,
  input  logic                      tp_bar,
  input  logic                      tp_hatch,
  output logic                      hsync_n,
  output logic                      vsync_n,
  output logic                      csync_n,
  output logic                      blank_n,
  output logic                      disp_en,
  output logic                      border,
  output logic [$clog2(ACT_W)-1:0]  pix_x,
  output logic [$clog2(ACT_H)-1:0]  line_y,
  output logic                      fsc,
  output logic [1:0]                rgb_sel
);
  localparam tmg_t TN = '{hsync: TW'(N_HSYNC), hlead: TW'(N_HLEAD), hact: TW'(ACT_W),
                          htrail: TW'(N_HTRAIL), hporch: TW'(N_HPORCH),
                          vsync: TW'(N_VSYNC), vblank: TW'(N_VBLANK), vlead: TW'(N_VLEAD),
                          vact: TW'(ACT_H), vtrail: TW'(N_VTRAIL)};
  localparam tmg_t TP = '{hsync: TW'(P_HSYNC), hlead: TW'(P_HLEAD), hact: TW'(ACT_W),
                          htrail: TW'(P_HTRAIL), hporch: TW'(P_HPORCH),
                          vsync: TW'(P_VSYNC), vblank: TW'(P_VBLANK), vlead: TW'(P_VLEAD),
                          vact: TW'(ACT_H), vtrail: TW'(P_VTRAIL)};
  localparam int HT_N   = int'(line_total(TN));
  localparam int HT_P   = int'(line_total(TP));
  localparam int VT_N   = int'(field_total(TN));
  localparam int VT_P   = int'(field_total(TP));
  localparam int HT_MAX = (HT_N > HT_P) ? HT_N : HT_P;
  localparam int VT_MAX = (VT_N > VT_P) ? VT_N : VT_P;
  localparam int HW     = $clog2(HT_MAX + 1);
  localparam int VW     = $clog2(VT_MAX + 2);
  localparam int PXW    = $clog2(ACT_W);
  localparam int PYW    = $clog2(ACT_H);

  logic [HW-1:0] dot, line_len;
  logic [VW-1:0] line, field_len;
  logic          line_end, field_end, odd_field, cur_std, cur_il;
  tmg_t          tm_cur;

  assign line_len  = cur_std ? HW'(HT_N) : HW'(HT_P);
  assign field_len = cur_std ? VW'(VT_N) : VW'(VT_P);
  assign tm_cur    = cur_std ? TN : TP;

  vrg_line_ctr #(.HW(HW)) u_line (
    .clk(clk), .rst_n(rst_n), .line_len(line_len), .dot(dot), .line_end(line_end)
  );

  vrg_field_ctr #(.VW(VW)) u_field (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .std_req(std_ntsc), .il_req(ilace_en),
    .field_len(field_len), .line(line), .odd_field(odd_field), .cur_std(cur_std),
    .cur_il(cur_il), .field_end(field_end)
  );

  vrg_raster_dec #(.HW(HW), .VW(VW), .PXW(PXW), .PYW(PYW)) u_dec (
    .tm(tm_cur), .dot(dot), .line(line), .odd_field(odd_field), .cur_il(cur_il),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n), .disp_en(disp_en),
    .border(border), .pix_x(pix_x), .line_y(line_y)
  );

  vrg_subcarrier #(.DIV(FSC_DIV)) u_fsc (.clk(clk), .rst_n(rst_n), .fsc(fsc));

  assign csync_n = hsync_n & vsync_n;

  always_comb begin
    if (tp_mute)       rgb_sel = SRC_MUTE;
    else if (tp_bar)   rgb_sel = SRC_BAR;
    else if (tp_hatch) rgb_sel = SRC_HATCH;
    else               rgb_sel = SRC_PIXEL;
  end
endmodule

// File: rtl/vrg_checker.sv
module vrg_checker #(
  parameter int PXW  = 9,
  parameter int HT_N = 455,
  parameter int HT_P = 567
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hsync_n,
  input logic           vsync_n,
  input logic           blank_n,
  input logic           disp_en,
  input logic           border,
  input logic [PXW-1:0] pix_x,
  input logic           fsc,
  input logic           cur_std,
  input logic           line_end
);
  localparam logic [15:0] LEN_N = 16'(HT_N);
  localparam logic [15:0] LEN_P = 16'(HT_P);

  logic        hs_prev, prev_std, hs_fell;
  logic [15:0] run_len;

  assign hs_fell = hs_prev & ~hsync_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_prev  <= 1'b0;
      prev_std <= cur_std;
      run_len  <= '0;
    end else begin
      hs_prev  <= hsync_n;
      prev_std <= cur_std;
      run_len  <= hs_fell ? 16'd1 : run_len + 16'd1;
    end
  end

  AST_LINE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fell |-> run_len == (prev_std ? LEN_N : LEN_P)); // R1
  AST_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> !hsync_n); // R1
  AST_SYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_n || !vsync_n) |-> !blank_n); // R5
  AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (hsync_n && vsync_n && blank_n && !border)); // R6
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |=> (!disp_en || pix_x == PXW'($past(pix_x) + 1'b1))); // R6
  AST_FSC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsc) |=> fsc ##1 !fsc); // R8
  AST_FSC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsc) |=> !fsc ##1 fsc); // R8
endmodule

bind vid_raster_gen vrg_checker #(
  .PXW($clog2(ACT_W)), .HT_N(HT_N), .HT_P(HT_P)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n),
  .disp_en(disp_en), .border(border), .pix_x(pix_x), .fsc(fsc), .cur_std(cur_std),
  .line_end(line_end)
);

// File: tb/sim_vid_raster_gen.sv
module sim_vid_raster_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  // segment tables: hsync, left border, window, right border, porch,
  //                 vsync, vblank, top border, window, bottom border
  localparam int SM_N[10] = '{5, 3, 8, 4, 2, 2, 2, 2, 5, 3};
  localparam int SM_P[10] = '{6, 4, 8, 5, 3, 2, 3, 3, 5, 4};
  localparam int DF_N[10] = '{68, 44, 288, 45, 10, 3, 17, 25, 192, 25};
  localparam int DF_P[10] = '{94, 84, 288, 88, 13, 3, 22, 47, 192, 48};

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [1:0] rst_n = 2'b00;
  logic [1:0] std_i = 2'b00;
  logic [1:0] il_i  = 2'b00;
  logic mute = 1'b0, bar = 1'b0, hatch = 1'b0;

  logic o0_hs, o0_vs, o0_cs, o0_bl, o0_de, o0_bd, o0_fsc;
  logic [2:0] o0_px, o0_ly;
  logic [1:0] o0_sel;
  logic o1_hs, o1_vs, o1_cs, o1_bl, o1_de, o1_bd, o1_fsc;
  logic [8:0] o1_px;
  logic [7:0] o1_ly;
  logic [1:0] o1_sel;

  vid_raster_gen #(
    .N_HSYNC(5), .N_HLEAD(3), .N_HTRAIL(4), .N_HPORCH(2),
    .P_HSYNC(6), .P_HLEAD(4), .P_HTRAIL(5), .P_HPORCH(3),
    .ACT_W(8), .ACT_H(5),
    .N_VSYNC(2), .N_VBLANK(2), .N_VLEAD(2), .N_VTRAIL(3),
    .P_VSYNC(2), .P_VBLANK(3), .P_VLEAD(3), .P_VTRAIL(4)
  ) u0 (
    .clk(clk), .rst_n(rst_n[0]), .std_ntsc(std_i[0]), .ilace_en(il_i[0]),
    .tp_mute(mute), .tp_bar(bar), .tp_hatch(hatch),
    .hsync_n(o0_hs), .vsync_n(o0_vs), .csync_n(o0_cs), .blank_n(o0_bl),
    .disp_en(o0_de), .border(o0_bd), .pix_x(o0_px), .line_y(o0_ly),
    .fsc(o0_fsc), .rgb_sel(o0_sel)
  );

  vid_raster_gen u1 (
    .clk(clk), .rst_n(rst_n[1]), .std_ntsc(std_i[1]), .ilace_en(il_i[1]),
    .tp_mute(1'b0), .tp_bar(1'b0), .tp_hatch(1'b0),
    .hsync_n(o1_hs), .vsync_n(o1_vs), .csync_n(o1_cs), .blank_n(o1_bl),
    .disp_en(o1_de), .border(o1_bd), .pix_x(o1_px), .line_y(o1_ly),
    .fsc(o1_fsc), .rgb_sel(o1_sel)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int mh[2], mv[2], mf[2], ms[2], mi[2], mk[2];

  function automatic int cst(int d, int s, int i);
    if (d == 0) return (s != 0) ? SM_N[i] : SM_P[i];
    return (s != 0) ? DF_N[i] : DF_P[i];
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset(int d);
    mh[d] = 0; mv[d] = 0; mf[d] = 0; mk[d] = 0;
    ms[d] = int'(std_i[d]); mi[d] = int'(il_i[d]);
  endtask

  task automatic model_step(int d);
    int ht, vt;
    ht = 0; vt = 0;
    for (int i = 0; i < 5; i++) ht += cst(d, ms[d], i);
    for (int i = 5; i < 10; i++) vt += cst(d, ms[d], i);
    if (mi[d] != 0 && mf[d] != 0) vt++;
    mk[d]++;
    if (mh[d] == ht - 1) begin
      mh[d] = 0;
      if (mv[d] == vt - 1) begin
        mv[d] = 0;
        mf[d] = (il_i[d] && mf[d] == 0) ? 1 : 0;
        ms[d] = int'(std_i[d]);
        mi[d] = int'(il_i[d]);
      end else mv[d]++;
    end else mh[d]++;
  endtask

  task automatic compare(int d, string pfx);
    int c[10];
    int ht, h, v, half, x0, y0, e_hs, e_vs, e_bl, e_de;
    bit odd, vlow, hbl, vbl;
    int ob[9];
    string vt;
    ht = 0;
    for (int i = 0; i < 10; i++) c[i] = cst(d, ms[d], i);
    for (int i = 0; i < 5; i++) ht += c[i];
    h = mh[d]; v = mv[d]; half = ht / 2;
    odd = (mi[d] != 0) && (mf[d] != 0);
    vt = (mi[d] != 0) ? "R4" : "R3";
    if (odd) vlow = (v == 0 && h >= half) || (v >= 1 && v < c[5]) || (v == c[5] && h < half);
    else     vlow = (v < c[5]);
    hbl = (h < c[0]) || (h >= ht - c[4]);
    vbl = (v < c[5] + c[6]);
    x0 = c[0] + c[1]; y0 = c[5] + c[6] + c[7];
    e_de = (h >= x0 && h < x0 + c[2] && v >= y0 && v < y0 + c[8]) ? 1 : 0;
    e_hs = (h < c[0]) ? 0 : 1;
    e_vs = vlow ? 0 : 1;
    e_bl = (hbl || vbl) ? 0 : 1;
    if (d == 0) ob = '{int'(o0_hs), int'(o0_vs), int'(o0_cs), int'(o0_bl), int'(o0_de),
                       int'(o0_bd), int'(o0_px), int'(o0_ly), int'(o0_fsc)};
    else        ob = '{int'(o1_hs), int'(o1_vs), int'(o1_cs), int'(o1_bl), int'(o1_de),
                       int'(o1_bd), int'(o1_px), int'(o1_ly), int'(o1_fsc)};
    chk({pfx, "R1 hsync_n"}, ob[0], e_hs);
    chk({pfx, vt, " vsync_n"}, ob[1], e_vs);
    chk({pfx, "R5 csync_n"}, ob[2], e_hs & e_vs);
    chk({pfx, "R2 blank_n"}, ob[3], e_bl);
    chk({pfx, "R6 disp_en"}, ob[4], e_de);
    chk({pfx, "R7 border"}, ob[5], (e_bl == 1 && e_de == 0) ? 1 : 0);
    chk({pfx, "R6 pix_x"}, ob[6], (e_de != 0) ? h - x0 : 0);
    chk({pfx, "R6 line_y"}, ob[7], (e_de != 0) ? v - y0 : 0);
    chk({pfx, "R8 fsc"}, ob[8], (mk[d] / 2) % 2);
  endtask

  task automatic do_reset(int d, bit s, bit i);
    @(negedge clk);
    rst_n[d] = 1'b0; std_i[d] = s; il_i[d] = i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n[d] = 1'b1;
    model_reset(d);
  endtask

  task automatic run(int d, int n, string pfx);
    for (int k = 0; k < n; k++) begin
      compare(d, pfx);
      @(posedge clk);
      model_step(d);
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic small_sweep;
    for (int m = 0; m < 4; m++) begin
      int ht, vt;
      bit s, i;
      s = m[1]; i = m[0];
      do_reset(0, s, i);
      // R11: reset state at line 0 dot 0
      chk("R11 hsync_n", int'(o0_hs), 0);
      chk("R11 vsync_n", int'(o0_vs), 0);
      chk("R11 csync_n", int'(o0_cs), 0);
      chk("R11 blank_n", int'(o0_bl), 0);
      chk("R11 disp_en", int'(o0_de), 0);
      chk("R11 fsc", int'(o0_fsc), 0);
      ht = 0; vt = 0;
      for (int k = 0; k < 5; k++) ht += cst(0, s, k);
      for (int k = 5; k < 10; k++) vt += cst(0, s, k);
      run(0, 3 * (vt + 1) * ht, "");
    end
    // R10: mode change in mid-field waits for the field boundary
    do_reset(0, 1'b1, 1'b0);
    run(0, 100, "R10 ");
    std_i[0] = 1'b0; il_i[0] = 1'b1;
    run(0, 5 * 18 * 26, "R10 ");
    std_i[0] = 1'b1; il_i[0] = 1'b0;
    run(0, 3 * 15 * 22, "R10 ");
    // R9: colour source priority over every request combination
    for (int p = 0; p < 8; p++) begin
      int e;
      {mute, bar, hatch} = 3'(p);
      #1;
      e = mute ? 1 : bar ? 2 : hatch ? 3 : 0;
      chk("R9 rgb_sel", int'(o0_sel), e);
      chk("R9 rgb_sel default bench", int'(o1_sel), 0);
    end
    {mute, bar, hatch} = 3'b000;
  endtask

  task automatic full_size;
    do_reset(1, 1'b1, 1'b0);
    chk("R11 blank_n full size", int'(o1_bl), 0);
    run(1, 455 * 265, "");
    do_reset(1, 1'b0, 1'b1);
    run(1, 567 * 4, "");
  endtask

  initial begin
    fork
      small_sweep();
      full_size();
    join
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule